// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage for register-to-register data-processing operations. The first operand comes from a register. The second operand arrives already shifted, together with the carry bit that the shifter produced. A 4-bit opcode selects one of sixteen operations: six add and subtract forms (two of them reverse the operand order), six logical and move forms, and four test or compare forms. The block returns the result, new N, Z, C and V flags, and a write-enable for the destination register. The write-enable is low for the test and compare forms.

Carry follows the "carry means no borrow" convention. A subtract computes `a + ~b + 1`, and subtract-with-carry computes `a - b + C - 1`, so C = 1 on a subtract means that no borrow occurred. Logical forms take C from the shifter and pass V through unchanged from the incoming flags.

One operation flows through a single registered stage with a valid/ready handshake on each side. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stops the producer after one operation. While `out_valid` is high and `out_ready` is low, every output holds its value.

Top module: `dp_alu`

## Requirements
- R1: The arithmetic opcodes produce these results. ADD 0100 gives a+b. ADC 0101 gives a+b+C. SUB 0010 gives a-b. SBC 0110 gives a-b+C-1. RSB 0011 gives b-a. RSC 0111 gives b-a+C-1. C is `in_flags[1]`, a is `in_op_a` and b is `in_op_b`. All results are modulo 2^32, and `out_wr_en` is 1.
- R2: The logical opcodes produce these results. AND 0000 gives a&b. EOR 0001 gives a^b. ORR 1100 gives a|b. BIC 1110 gives a&~b. MOV 1101 gives b. MVN 1111 gives ~b. For all of them `out_wr_en` is 1.
- R3: The test and compare opcodes produce `out_wr_en` = 0 and set the flags. TST 1000 uses a&b, TEQ 1001 uses a^b, CMP 1010 uses a-b and CMN 1011 uses a+b.
- R4: The flags vector is ordered [3]=N, [2]=Z, [1]=C, [0]=V. N equals bit 31 of the computed value, and Z is 1 exactly when all 32 bits of the computed value are zero.
- R5: For the arithmetic and compare forms, C is the carry out of bit 31 of the adder. For the subtract forms this means C = 1 exactly when no borrow occurs.
- R6: For the arithmetic and compare forms, V is 1 exactly when the true signed result does not fit in 32 bits.
- R7: For the logical, move and test forms, C equals `in_shift_c` and V equals `in_flags[0]`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result`, `out_flags` and `out_wr_en` hold their values. `in_ready` is high exactly when the output stage is empty or is being drained. Operations leave the block in the order they were accepted.
- R9: In the cycle after reset is asserted, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present on the input |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_opcode | input | 4 | Operation select |
| in_op_a | input | 32 | First operand, from a register |
| in_op_b | input | 32 | Second operand, already shifted |
| in_shift_c | input | 1 | Carry-out of the shifter |
| in_flags | input | 4 | Current N, Z, C, V |
| out_valid | output | 1 | Result present on the output |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Computed value |
| out_flags | output | 4 | New N, Z, C, V |
| out_wr_en | output | 1 | Write result to the destination register |

## Verification
The bench builds the block with the default width of 32. With that width, a 64-bit signed reference can compute every add and subtract form exactly, so carry and overflow can be judged against the true mathematical result rather than against bit tricks. Operand corners are chosen to reach the wrap points at 0x7FFFFFFF/0x80000000 and 0xFFFFFFFF/0. Both carry-in values are applied to every carrying form. A pseudo-random consumer stall pattern exercises the hold rule and the ordering of back-to-back operations.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
    OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
    OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
    OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Opcodes 0010..0111 and 1010..1011 use the adder
  function automatic logic uses_adder(alu_op_e op);
    return (op[3:2] == 2'b01) || (op[3:1] == 3'b001) || (op[3:1] == 3'b101);
  endfunction

  function automatic logic is_test(alu_op_e op);
    return op[3:2] == 2'b10;
  endfunction

endpackage

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             overflow
);

  localparam int MSB = WIDTH - 1;

  logic             swap_ops;
  logic             negate;
  logic             cin_sel;
  logic [WIDTH-1:0] x_opd;
  logic [WIDTH-1:0] y_raw;
  logic [WIDTH-1:0] y_opd;
  logic [WIDTH:0]   wide_sum;

  always_comb begin
    swap_ops = (op == OP_RSB) || (op == OP_RSC);
    negate   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || swap_ops;
    unique case (op)
      OP_ADC, OP_SBC, OP_RSC: cin_sel = carry_in;
      OP_SUB, OP_RSB, OP_CMP: cin_sel = 1'b1;
      default:                cin_sel = 1'b0;
    endcase
  end

  assign x_opd    = swap_ops ? b : a;
  assign y_raw    = swap_ops ? a : b;
  assign y_opd    = negate ? ~y_raw : y_raw;
  assign wide_sum = {1'b0, x_opd} + {1'b0, y_opd} + {{WIDTH{1'b0}}, cin_sel};

  assign sum       = wide_sum[MSB:0];
  assign carry_out = wide_sum[WIDTH];
  assign overflow  = (x_opd[MSB] == y_opd[MSB]) && (sum[MSB] != x_opd[MSB]);

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] value
);

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: value = a & b;
      OP_EOR, OP_TEQ: value = a ^ b;
      OP_ORR:         value = a | b;
      OP_BIC:         value = a & ~b;
      OP_MOV:         value = b;
      OP_MVN:         value = ~b;
      default:        value = '0;
    endcase
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_opcode,
  input  logic [WIDTH-1:0] in_op_a,
  input  logic [WIDTH-1:0] in_op_b,
  input  logic             in_shift_c,
  input  logic [3:0]       in_flags,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result,
  output logic [3:0]       out_flags,
  output logic             out_wr_en
);

  localparam int MSB = WIDTH - 1;

  alu_op_e          op;
  nzcv_t            cur;
  nzcv_t            nxt;
  logic [WIDTH-1:0] arith_val;
  logic [WIDTH-1:0] logic_val;
  logic [WIDTH-1:0] value;
  logic             arith_c;
  logic             arith_v;
  logic             take;

  assign op  = alu_op_e'(in_opcode);
  assign cur = nzcv_t'(in_flags);

  dp_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .op        (op),
    .a         (in_op_a),
    .b         (in_op_b),
    .carry_in  (cur.c),
    .sum       (arith_val),
    .carry_out (arith_c),
    .overflow  (arith_v)
  );

  dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op    (op),
    .a     (in_op_a),
    .b     (in_op_b),
    .value (logic_val)
  );

  always_comb begin
    value = uses_adder(op) ? arith_val : logic_val;
    nxt.n = value[MSB];
    nxt.z = (value == '0);
    nxt.c = uses_adder(op) ? arith_c : in_shift_c;
    nxt.v = uses_adder(op) ? arith_v : cur.v;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_result <= value;
      out_flags  <= nxt;
      out_wr_en  <= !is_test(op);
    end
  end

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_opcode,
  input logic [WIDTH-1:0] in_op_a,
  input logic [WIDTH-1:0] in_op_b,
  input logic [3:0]       in_flags,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result,
  input logic [3:0]       out_flags,
  input logic             out_wr_en
);

  logic acc;
  assign acc = in_valid && in_ready;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R9

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable(out_flags) && $stable(out_wr_en)); // R8

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_opcode[3:2] == 2'b10 |=> !out_wr_en); // R3

  AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_opcode[2:1] == 2'b00 || in_opcode[3:2] == 2'b11)
      |=> out_flags[0] == $past(in_flags[0])); // R7

  AST_MOV_PASSES_B: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_opcode == 4'b1101 |=> out_result == $past(in_op_b)); // R2

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_opcode == 4'b0100
      |=> out_flags[1] == ($past({1'b0, in_op_a} + {1'b0, in_op_b}) > {1'b0, {WIDTH{1'b1}}})); // R5

endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_opcode  (in_opcode),
  .in_op_a    (in_op_a),
  .in_op_b    (in_op_b),
  .in_flags   (in_flags),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_flags  (out_flags),
  .out_wr_en  (out_wr_en)
);

// File: tb/dp_alu_bench.sv
`timescale 1ns/1ps
module dp_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_opcode = '0;
  logic [31:0] in_op_a = '0;
  logic [31:0] in_op_b = '0;
  logic        in_shift_c = 1'b0;
  logic [3:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic [3:0]  out_flags;
  logic        out_wr_en;

  always #2.5 clk = ~clk;

  dp_alu #(.WIDTH(32)) u_dp_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_op_a(in_op_a), .in_op_b(in_op_b),
    .in_shift_c(in_shift_c), .in_flags(in_flags), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags),
    .out_wr_en(out_wr_en)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] res;
    logic [3:0]  fl;
    logic        we;
  } exp_t;

  exp_t        sb_q[$];
  int          n_vec = 0;
  int          n_bad = 0;
  logic        run_done = 1'b0;
  logic        stall_ready = 1'b0;
  logic [31:0] rdy_lfsr = 32'h1234_5678;
  logic [31:0] seed = 32'hC0FF_EE11;
  logic        held_pending = 1'b0;
  logic [31:0] held_res;
  logic [3:0]  held_fl;

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  function automatic exp_t model(input logic [3:0] op, input logic [31:0] a,
                                 input logic [31:0] b, input logic sc, input logic [3:0] fl);
    exp_t   e;
    longint ua, ub, sa, sb, u, s, c;
    logic   arith, subf;
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    c  = longint'(fl[1]);
    arith = 1'b1;
    subf  = 1'b1;
    e.op  = op;
    e.we  = (op[3:2] != 2'b10);
    u = 0; s = 0;
    case (op)
      4'b0100, 4'b1011: begin u = ua + ub;         s = sa + sb;         subf = 1'b0; end
      4'b0101:          begin u = ua + ub + c;     s = sa + sb + c;     subf = 1'b0; end
      4'b0010, 4'b1010: begin u = ua - ub;         s = sa - sb;         end
      4'b0110:          begin u = ua - ub + c - 1; s = sa - sb + c - 1; end
      4'b0011:          begin u = ub - ua;         s = sb - sa;         end
      4'b0111:          begin u = ub - ua + c - 1; s = sb - sa + c - 1; end
      default: arith = 1'b0;
    endcase
    if (arith) begin
      e.res   = u[31:0];
      e.fl[1] = subf ? (u >= 0) : (u >= (longint'(1) << 32));
      e.fl[0] = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else begin
      case (op)
        4'b0000, 4'b1000: e.res = a & b;
        4'b0001, 4'b1001: e.res = a ^ b;
        4'b1100:          e.res = a | b;
        4'b1110:          e.res = a & ~b;
        4'b1101:          e.res = b;
        default:          e.res = ~b;
      endcase
      e.fl[1] = sc;
      e.fl[0] = fl[0];
    end
    e.fl[3] = e.res[31];
    e.fl[2] = (e.res == 32'd0);
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sc, input logic [3:0] fl);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = op; in_op_a = a; in_op_b = b;
    in_shift_c = sc; in_flags = fl;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    sb_q.push_back(model(op, a, b, sc, fl));
  endtask

  function automatic string tag_res(input logic [3:0] op);
    if (op[3:2] == 2'b10) return "R3";
    if (op[2:1] == 2'b00 || op[3:2] == 2'b11) return "R2";
    return "R1";
  endfunction

  function automatic logic is_arith(input logic [3:0] op);
    return (op[3:2] == 2'b01) || (op[3:1] == 3'b001) || (op[3:1] == 3'b101);
  endfunction

  // Monitor: picks a stall pattern, then scores any transfer in the coming edge
  always @(negedge clk) begin
    exp_t e;
    logic bad;
    rdy_lfsr = xs(rdy_lfsr);
    out_ready = stall_ready ? (rdy_lfsr[1:0] != 2'b00) : 1'b1;
    if (rst_n && held_pending && out_valid) begin
      n_vec++;
      if (out_result !== held_res || out_flags !== held_fl) begin
        n_bad++;
        $display("FAIL R8 held output changed: got %h/%h exp %h/%h", out_result, out_flags, held_res, held_fl);
      end
    end
    held_pending = rst_n && out_valid && !out_ready;
    held_res = out_result;
    held_fl  = out_flags;
    if (rst_n && out_valid && out_ready) begin
      n_vec++;
      bad = 1'b0;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R8 unexpected output: got %h exp none", out_result);
      end else begin
        e = sb_q.pop_front();
        if (out_result !== e.res) begin
          bad = 1'b1;
          $display("FAIL %s op %b result: got %h exp %h", tag_res(e.op), e.op, out_result, e.res);
        end
        if (out_wr_en !== e.we) begin
          bad = 1'b1;
          $display("FAIL R3 op %b wr_en: got %b exp %b", e.op, out_wr_en, e.we);
        end
        if (out_flags[3:2] !== e.fl[3:2]) begin
          bad = 1'b1;
          $display("FAIL R4 op %b NZ: got %b exp %b", e.op, out_flags[3:2], e.fl[3:2]);
        end
        if (out_flags[1] !== e.fl[1]) begin
          bad = 1'b1;
          $display("FAIL %s op %b C: got %b exp %b", is_arith(e.op) ? "R5" : "R7", e.op, out_flags[1], e.fl[1]);
        end
        if (out_flags[0] !== e.fl[0]) begin
          bad = 1'b1;
          $display("FAIL %s op %b V: got %b exp %b", is_arith(e.op) ? "R6" : "R7", e.op, out_flags[0], e.fl[0]);
        end
        if (bad) n_bad++;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!run_done) begin
      n_bad++;
      $display("FAIL watchdog expired: got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0) begin   // R9
      n_bad++;
      $display("FAIL R9 out_valid in reset: got %b exp 0", out_valid);
    end
    rst_n = 1'b1;

    // R1/R5/R6 corners
    drive(4'b0100, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 4'b0000); // ADD signed overflow
    drive(4'b0100, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 4'b0000); // ADD carry, zero
    drive(4'b0101, 32'hFFFF_FFFE, 32'h0000_0001, 1'b0, 4'b0010); // ADC with C=1 wraps
    drive(4'b0010, 32'h0000_0005, 32'h0000_0005, 1'b0, 4'b0000); // SUB equal: C=1, Z=1
    drive(4'b0010, 32'h0000_0003, 32'h0000_0005, 1'b0, 4'b0000); // SUB borrow: C=0
    drive(4'b0010, 32'h8000_0000, 32'h0000_0001, 1'b0, 4'b0000); // SUB signed overflow
    drive(4'b0110, 32'h0000_0005, 32'h0000_0005, 1'b0, 4'b0000); // SBC C=0 -> -1
    drive(4'b0110, 32'h0000_0005, 32'h0000_0005, 1'b0, 4'b0010); // SBC C=1 -> 0
    drive(4'b0011, 32'h0000_0001, 32'h0000_000A, 1'b0, 4'b0000); // RSB b-a
    drive(4'b0111, 32'h0000_000A, 32'h0000_0001, 1'b0, 4'b0000); // RSC borrow
    drive(4'b0111, 32'h0000_0000, 32'h8000_0000, 1'b0, 4'b0000); // RSC overflow
    // R3 compares
    drive(4'b1010, 32'h0000_0010, 32'h0000_0010, 1'b0, 4'b0001);
    drive(4'b1011, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'b0000);
    drive(4'b1000, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b1, 4'b0001);
    drive(4'b1001, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, 4'b1111);
    // R2/R7 logical, V kept and C from shifter
    drive(4'b0000, 32'hFFFF_0000, 32'h0F0F_0F0F, 1'b1, 4'b0001);
    drive(4'b0001, 32'hFFFF_0000, 32'h0F0F_0F0F, 1'b0, 4'b0011);
    drive(4'b1100, 32'h0000_0000, 32'h0000_0000, 1'b1, 4'b0000);
    drive(4'b1110, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 4'b0001);
    drive(4'b1101, 32'h1234_5678, 32'h8765_4321, 1'b1, 4'b0000);
    drive(4'b1111, 32'h0, 32'h0, 1'b0, 4'b0001);

    // R8 under consumer stalls, every opcode with random data
    stall_ready = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      seed = xs(seed); a = seed;
      seed = xs(seed); b = (seed[3:0] == 4'd0) ? a : seed;
      seed = xs(seed);
      drive(4'(i % 16), a, b, seed[4], seed[3:0]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    stall_ready = 1'b0;
    repeat (20) @(negedge clk);
    n_vec++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R8 outputs missing: got %0d left exp 0", sb_q.size());
    end
    run_done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule